// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the host-facing register file of a simple LCD panel controller. A host reaches six 32-bit registers through a single-cycle valid/write/address/data port: control, three timing words, status and subpanel. The block keeps the panel mode fields and the panel width and height. It exports these values to a frame-fetch engine, which sits outside this block.

A write that flips the enable bit produces a one-cycle notification pulse for the engine. The engine in turn reports frame-done, palette-done and sync-error events. The block latches these events into sticky status flags. The flags are combined with a two-bit mask into one level-sensitive interrupt line. Reads are combinational and return the stored fields with a set of constant one bits forced in. The timing registers take "size minus one" from the host and store the true panel size.

Top module: `lcd_regif`

## Requirements
- R1: A write at offset 0x00 stores these control fields:
  - load mode from bits 21:20
  - TFT select from bit 7
  - interrupt mask from bits 4:3
  - mono select from bit 1
  - enable from bit 0
  - the bits under mask 0x01cff300 as a general field

  A read at 0x00 returns, ORed together: the general field, each field at its write position, TFT copied again into bit 23, and the constant 0xfe000c34.
- R2: A write at offset 0x04 sets the panel width to bits 9:0 plus one and stores bits 31:10. A read at 0x04 returns the stored upper bits at 31:10, ORed with (width minus one) in bits 9:0 and with 0xf.
- R3: Offset 0x08 behaves like offset 0x04, but for the panel height and without the forced low bits.
- R4: A write at offset 0x0c stores the full word. A read at 0x0c returns it with bits 31:26 forced to one.
- R5: Offset 0x10 is read-only status. Bit 6 is palette-done, bit 2 is sync-error and bit 0 is frame-done. A write to 0x10 changes nothing.
- R6: A write at offset 0x14 stores the data ANDed with 0xa1ffffff. A read at 0x14 returns the stored value, which is also driven on `subpanel_cfg`.
- R7: `irq` is high exactly when any of these holds:
  - frame-done and mask bit 0 are both set
  - palette-done and mask bit 1 are both set
  - sync-error is set, whatever the mask
- R8: A control write that clears enable (1 to 0) clears sync-error. It also sets frame-done, unless the new load mode equals 1.
- R9: A control write that sets enable (0 to 1) clears frame-done and palette-done.
- R10: `enable_changed` is high for exactly one cycle, in the cycle after a control write that changes enable. A control write that keeps enable produces no pulse.
- R11: Each event input sets its own status flag. The flag stays set until an enable change clears it. When an event arrives in the same cycle as an enable change that writes the same flag, the enable change wins.
- R12: After reset every register and flag is zero. The reads are then: control 0xfe000c34, offsets 0x04 and 0x08 each 0x000003ff, offset 0x0c 0xfc000000, and status and subpanel 0. `irq` is low, and `panel_width` and `panel_height` are 0.
- R13: A read at any other offset returns zero. A write at any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| evt_frame_done | input | 1 | Frame-done event from the fetch engine |
| evt_palette_done | input | 1 | Palette-done event from the fetch engine |
| evt_sync_error | input | 1 | Sync-error event from the fetch engine |
| panel_enable | output | 1 | Current enable bit |
| enable_changed | output | 1 | One-cycle pulse after enable changes |
| load_mode | output | 2 | Load mode field |
| tft_sel | output | 1 | TFT select |
| mono_sel | output | 1 | Mono select |
| panel_width | output | DIM_W+1 | Stored width |
| panel_height | output | DIM_W+1 | Stored height |
| subpanel_cfg | output | 32 | Stored subpanel word |
| irq | output | 1 | Level interrupt |

## Verification
An event from the fetch engine can arrive in the same cycle as a host control write that flips enable. Both then try to update the same status flag. The bench provokes this by driving the disable write together with a sync-error event, and the enable write together with a frame-done event. It then reads status and expects the flag value that the enable change dictates. A disable in load mode 1 combined with a frame-done event is also driven, to confirm that the event still sets the flag when the enable change leaves that flag alone.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 6;
  localparam int REG_STRIDE = 4;

  localparam int SEL_CTRL = 0;
  localparam int SEL_TIM0 = 1;
  localparam int SEL_TIM1 = 2;
  localparam int SEL_TIM2 = 3;
  localparam int SEL_STAT = 4;
  localparam int SEL_SUBP = 5;

  localparam logic [DATA_W-1:0] CTRL_GEN_MASK = 32'h01cf_f300;
  localparam logic [DATA_W-1:0] CTRL_RD_ONES  = 32'hfe00_0c34;
  localparam logic [DATA_W-1:0] TIM0_RD_ONES  = 32'h0000_000f;
  localparam logic [DATA_W-1:0] TIM1_RD_ONES  = 32'h0000_0000;
  localparam logic [DATA_W-1:0] TIM2_RD_ONES  = 32'hfc00_0000;
  localparam logic [DATA_W-1:0] SUBP_WR_MASK  = 32'ha1ff_ffff;

  localparam int CB_EN     = 0;
  localparam int CB_MONO   = 1;
  localparam int CB_MASK   = 3;
  localparam int CB_TFT    = 7;
  localparam int CB_MODE   = 20;
  localparam int CB_TFT_HI = 23;

  localparam int SB_FRAME = 0;
  localparam int SB_SYNC  = 2;
  localparam int SB_PAL   = 6;

  localparam logic [1:0] MODE_NO_FRAME_FLAG = 2'd1;

  typedef struct packed {
    logic [1:0] load_mode;
    logic       tft;
    logic [1:0] irq_mask;
    logic       mono;
    logic       enable;
  } ctrl_fields_t;
endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode #(
  parameter int ADDR_W = 8,
  parameter int NUM    = lcd_regif_pkg::NUM_REGS,
  parameter int STRIDE = lcd_regif_pkg::REG_STRIDE
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM-1:0]    sel
);
  generate
    for (genvar i = 0; i < NUM; i++) begin : g_sel
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(i * STRIDE);
      assign sel[i] = valid && (addr == OFFS);
    end
  endgenerate
endmodule

// File: rtl/lcd_regif_ctrl.sv
module lcd_regif_ctrl
  import lcd_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_fields_t      fields,
  output logic [DATA_W-1:0] gen_field,
  output logic              en_rise,
  output logic              en_fall,
  output logic              en_pulse
);
  ctrl_fields_t      fields_q, fields_n;
  logic [DATA_W-1:0] gen_q, gen_n;
  logic              pulse_q, pulse_n;

  always_comb begin
    fields_n = fields_q;
    gen_n    = gen_q;
    if (wr_en) begin
      fields_n.load_mode = wdata[CB_MODE +: 2];
      fields_n.tft       = wdata[CB_TFT];
      fields_n.irq_mask  = wdata[CB_MASK +: 2];
      fields_n.mono      = wdata[CB_MONO];
      fields_n.enable    = wdata[CB_EN];
      gen_n              = wdata & CTRL_GEN_MASK;
    end
    en_rise = wr_en &&  wdata[CB_EN] && !fields_q.enable;
    en_fall = wr_en && !wdata[CB_EN] &&  fields_q.enable;
    pulse_n = en_rise || en_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      gen_q    <= '0;
      pulse_q  <= 1'b0;
    end else begin
      fields_q <= fields_n;
      gen_q    <= gen_n;
      pulse_q  <= pulse_n;
    end
  end

  assign fields    = fields_q;
  assign gen_field = gen_q;
  assign en_pulse  = pulse_q;
endmodule

// File: rtl/lcd_regif_dim.sv
module lcd_regif_dim #(
  parameter int          DIM_W    = 10,
  parameter logic [31:0] RD_ONES  = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [DIM_W:0] dim,
  output logic [31:0]   rd_val
);
  localparam int UP_W = 32 - DIM_W;

  logic [DIM_W:0]  dim_q, dim_n;
  logic [UP_W-1:0] up_q, up_n;
  logic [DIM_W:0]  dim_m1;

  always_comb begin
    dim_n = dim_q;
    up_n  = up_q;
    if (wr_en) begin
      dim_n = {1'b0, wdata[DIM_W-1:0]} + 1'b1;
      up_n  = wdata[31:DIM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_q <= '0;
      up_q  <= '0;
    end else begin
      dim_q <= dim_n;
      up_q  <= up_n;
    end
  end

  assign dim_m1 = dim_q - 1'b1;
  assign dim    = dim_q;
  assign rd_val = {up_q, dim_m1[DIM_W-1:0]} | RD_ONES;
endmodule

// File: rtl/lcd_regif_flags.sv
module lcd_regif_flags
  import lcd_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic [1:0] new_mode,
  input  logic [1:0] irq_mask,
  input  logic       evt_frame,
  input  logic       evt_pal,
  input  logic       evt_sync,
  output logic       frame_done,
  output logic       palette_done,
  output logic       sync_err,
  output logic       irq
);
  logic fd_q, fd_n, pd_q, pd_n, se_q, se_n;

  always_comb begin
    fd_n = fd_q | evt_frame;
    pd_n = pd_q | evt_pal;
    se_n = se_q | evt_sync;
    if (en_fall) begin
      se_n = 1'b0;
      if (new_mode != MODE_NO_FRAME_FLAG) fd_n = 1'b1;
    end
    if (en_rise) begin
      fd_n = 1'b0;
      pd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= 1'b0;
      pd_q <= 1'b0;
      se_q <= 1'b0;
    end else begin
      fd_q <= fd_n;
      pd_q <= pd_n;
      se_q <= se_n;
    end
  end

  assign frame_done   = fd_q;
  assign palette_done = pd_q;
  assign sync_err     = se_q;
  assign irq = (fd_q && irq_mask[0]) || (pd_q && irq_mask[1]) || se_q;
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcd_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_frame_done,
  input  logic              evt_palette_done,
  input  logic              evt_sync_error,
  output logic              panel_enable,
  output logic              enable_changed,
  output logic [1:0]        load_mode,
  output logic              tft_sel,
  output logic              mono_sel,
  output logic [DIM_W:0]    panel_width,
  output logic [DIM_W:0]    panel_height,
  output logic [31:0]       subpanel_cfg,
  output logic              irq
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wsel;
  ctrl_fields_t        cf;
  logic [31:0]         gen_field;
  logic                en_rise, en_fall;
  logic [31:0]         tim0_rd, tim1_rd;
  logic [31:0]         tim2_q, tim2_n, subp_q, subp_n;
  logic                frame_done, palette_done, sync_err;
  logic [31:0]         ctrl_rd, stat_rd;

  lcd_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(bus_valid), .addr(bus_addr), .sel(sel)
  );
  assign wsel = sel & {NUM_REGS{bus_write}};

  lcd_regif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[SEL_CTRL]), .wdata(bus_wdata),
    .fields(cf), .gen_field(gen_field), .en_rise(en_rise), .en_fall(en_fall),
    .en_pulse(enable_changed)
  );

  lcd_regif_dim #(.DIM_W(DIM_W), .RD_ONES(TIM0_RD_ONES)) u_width (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[SEL_TIM0]), .wdata(bus_wdata),
    .dim(panel_width), .rd_val(tim0_rd)
  );

  lcd_regif_dim #(.DIM_W(DIM_W), .RD_ONES(TIM1_RD_ONES)) u_height (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[SEL_TIM1]), .wdata(bus_wdata),
    .dim(panel_height), .rd_val(tim1_rd)
  );

  lcd_regif_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .en_fall(en_fall),
    .new_mode(bus_wdata[CB_MODE +: 2]), .irq_mask(cf.irq_mask),
    .evt_frame(evt_frame_done), .evt_pal(evt_palette_done),
    .evt_sync(evt_sync_error), .frame_done(frame_done),
    .palette_done(palette_done), .sync_err(sync_err), .irq(irq)
  );

  always_comb begin
    tim2_n = tim2_q;
    subp_n = subp_q;
    if (wsel[SEL_TIM2]) tim2_n = bus_wdata;
    if (wsel[SEL_SUBP]) subp_n = bus_wdata & SUBP_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim2_q <= '0;
      subp_q <= '0;
    end else begin
      tim2_q <= tim2_n;
      subp_q <= subp_n;
    end
  end

  always_comb begin
    ctrl_rd = CTRL_RD_ONES | gen_field;
    ctrl_rd[CB_TFT_HI]    = ctrl_rd[CB_TFT_HI] | cf.tft;
    ctrl_rd[CB_MODE +: 2] = ctrl_rd[CB_MODE +: 2] | cf.load_mode;
    ctrl_rd[CB_TFT]       = ctrl_rd[CB_TFT] | cf.tft;
    ctrl_rd[CB_MASK +: 2] = ctrl_rd[CB_MASK +: 2] | cf.irq_mask;
    ctrl_rd[CB_MONO]      = ctrl_rd[CB_MONO] | cf.mono;
    ctrl_rd[CB_EN]        = ctrl_rd[CB_EN] | cf.enable;
    stat_rd = '0;
    stat_rd[SB_FRAME] = frame_done;
    stat_rd[SB_SYNC]  = sync_err;
    stat_rd[SB_PAL]   = palette_done;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel[SEL_CTRL]) bus_rdata = ctrl_rd;
    if (sel[SEL_TIM0]) bus_rdata = tim0_rd;
    if (sel[SEL_TIM1]) bus_rdata = tim1_rd;
    if (sel[SEL_TIM2]) bus_rdata = tim2_q | TIM2_RD_ONES;
    if (sel[SEL_STAT]) bus_rdata = stat_rd;
    if (sel[SEL_SUBP]) bus_rdata = subp_q;
  end

  assign panel_enable = cf.enable;
  assign load_mode    = cf.load_mode;
  assign tft_sel      = cf.tft;
  assign mono_sel     = cf.mono;
  assign subpanel_cfg = subp_q;
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              panel_enable,
  input logic              enable_changed,
  input logic [1:0]        load_mode,
  input logic [DIM_W:0]    panel_width,
  input logic              frame_done,
  input logic              palette_done,
  input logic              sync_err,
  input logic              irq
);
  // R2
  width_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(4)) |=>
      panel_width == ({1'b0, $past(bus_wdata[DIM_W-1:0])} + 1'b1));

  // R7
  sync_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> irq);

  // R8
  fall_sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_enable) |-> !sync_err);

  // R8
  fall_frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(panel_enable) && load_mode != 2'd1) |-> frame_done);

  // R9
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_enable) |-> (!frame_done && !palette_done));

  // R10
  pulse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_changed == (panel_enable != $past(panel_enable)));
endmodule

bind lcd_regif lcd_regif_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .panel_enable(panel_enable),
  .enable_changed(enable_changed), .load_mode(load_mode),
  .panel_width(panel_width), .frame_done(frame_done),
  .palette_done(palette_done), .sync_err(sync_err), .irq(irq)
);

// File: tb/lcd_regif_tb_top.sv
module lcd_regif_tb_top;
  localparam int ADDR_W = 8;
  localparam int DIM_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              evt_f = 1'b0, evt_p = 1'b0, evt_s = 1'b0;
  logic              panel_enable, enable_changed, tft_sel, mono_sel, irq;
  logic [1:0]        load_mode;
  logic [DIM_W:0]    panel_width, panel_height;
  logic [31:0]       subpanel_cfg;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_regif #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_frame_done(evt_f), .evt_palette_done(evt_p), .evt_sync_error(evt_s),
    .panel_enable(panel_enable), .enable_changed(enable_changed),
    .load_mode(load_mode), .tft_sel(tft_sel), .mono_sel(mono_sel),
    .panel_width(panel_width), .panel_height(panel_height),
    .subpanel_cfg(subpanel_cfg), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drives a write (optionally with events) for one clock edge; returns at the next negedge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] ev = 3'b000);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    {evt_s, evt_p, evt_f} = ev;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; {evt_s, evt_p, evt_f} = 3'b000;
  endtask

  task automatic evt(input logic [2:0] ev);
    @(negedge clk);
    {evt_s, evt_p, evt_f} = ev;
    @(negedge clk);
    {evt_s, evt_p, evt_f} = 3'b000;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_exp(input logic [31:0] w);
    logic [31:0] r;
    r = 32'hfe000c34 | (w & 32'h01cff300);
    r = r | ({30'd0, w[21:20]} << 20) | ({31'd0, w[7]} << 23) | ({31'd0, w[7]} << 7);
    r = r | ({30'd0, w[4:3]} << 3) | ({31'd0, w[1]} << 1) | {31'd0, w[0]};
    return r;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R12 ctrl", d, 32'hfe000c34);
    rd(8'h04, d); check("R12 tim0", d, 32'h000003ff);
    rd(8'h08, d); check("R12 tim1", d, 32'h000003ff);
    rd(8'h0c, d); check("R12 tim2", d, 32'hfc000000);
    rd(8'h10, d); check("R12 status", d, 32'h0);
    rd(8'h14, d); check("R12 subpanel", d, 32'h0);
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R12 width", {21'd0, panel_width}, 32'd0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(8'h00, 32'h0030009a);
    check("R10 no pulse", {31'd0, enable_changed}, 32'd0);
    rd(8'h00, d); check("R1 ctrl a", d, ctrl_exp(32'h0030009a));
    wr(8'h00, 32'hfffffffe);
    rd(8'h00, d); check("R1 ctrl b", d, ctrl_exp(32'hfffffffe));
    check("R1 mode out", {30'd0, load_mode}, 32'd3);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R1 ctrl c", d, 32'hfe000c34);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    wr(8'h04, 32'h12345c7f);
    rd(8'h04, d); check("R2 tim0", d, 32'h12345c7f);
    check("R2 width", {21'd0, panel_width}, 32'h80);
    wr(8'h04, 32'h000003ff);
    check("R2 width max", {21'd0, panel_width}, 32'h400);
    wr(8'h08, 32'habcde7f0);
    rd(8'h08, d); check("R3 tim1", d, 32'habcde7f0);
    check("R3 height", {21'd0, panel_height}, 32'h3f1);
    wr(8'h0c, 32'h01234567);
    rd(8'h0c, d); check("R4 tim2", d, 32'hfd234567);
    wr(8'h14, 32'hffffffff);
    rd(8'h14, d); check("R6 subpanel", d, 32'ha1ffffff);
    check("R6 out", subpanel_cfg, 32'ha1ffffff);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h18, 32'hffffffff);
    wr(8'h02, 32'hffffffff);
    wr(8'h10, 32'hffffffff);
    rd(8'h10, d); check("R5 status write ignored", d, 32'h0);
    rd(8'h18, d); check("R13 read zero", d, 32'h0);
    rd(8'h00, d); check("R13 ctrl untouched", d, 32'hfe000c34);
    rd(8'h14, d); check("R13 subp untouched", d, 32'ha1ffffff);
    rd(8'h0c, d); check("R13 tim2 untouched", d, 32'hfd234567);
  endtask

  task automatic t_enable_irq;
    logic [31:0] d;
    wr(8'h00, 32'h1);
    check("R10 pulse", {31'd0, enable_changed}, 32'd1);
    @(negedge clk);
    check("R10 pulse one cycle", {31'd0, enable_changed}, 32'd0);
    rd(8'h10, d); check("R9 cleared", d, 32'h0);
    evt(3'b001);
    rd(8'h10, d); check("R11 frame flag", d, 32'h1);
    check("R7 masked", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h9);
    check("R10 keep no pulse", {31'd0, enable_changed}, 32'd0);
    check("R7 frame irq", {31'd0, irq}, 32'd1);
    evt(3'b010);
    rd(8'h10, d); check("R5 status layout", d, 32'h41);
    wr(8'h00, 32'h11);
    check("R7 pal irq", {31'd0, irq}, 32'd1);
    evt(3'b100);
    rd(8'h10, d); check("R11 sync flag", d, 32'h45);
    wr(8'h00, 32'h1);
    check("R7 sync unmasked", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h0);
    check("R10 fall pulse", {31'd0, enable_changed}, 32'd1);
    rd(8'h10, d); check("R8 disable", d, 32'h41);
    check("R7 irq low", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h1);
    rd(8'h10, d); check("R9 enable clears", d, 32'h0);
    wr(8'h00, 32'h00100000);
    rd(8'h10, d); check("R8 mode1 no frame", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h00, 32'h1, 3'b001);
    rd(8'h10, d); check("R11 rise beats frame evt", d, 32'h0);
    evt(3'b100);
    wr(8'h00, 32'h0, 3'b100);
    rd(8'h10, d); check("R11 fall beats sync evt", d, 32'h1);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h00100000, 3'b001);
    rd(8'h10, d); check("R11 mode1 fall keeps frame evt", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_timing();
    t_unmapped();
    t_enable_irq();
    t_collide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule